// File: doc/BRIEF.md
# Clock-Monitor Reference and Start-Up Divider

This block produces the slowed reference clocks that a clock monitor compares against each other. One reference is taken from the external crystal clock and one from the internal base clock. Each source first passes through a divide-by-4 stage. A slow-crystal select then decides which of the two sources also receives the long prescaler, so that each reference runs well below the frequency of the opposite source. The frequency comparison itself sits outside this block.

A single 4096-count divider, clocked by the external clock, has two jobs. When the external generator is enabled it first acts as a crystal start-up timer. It drives a stabilization clock, and the stable flag rises on that clock's falling edge. After that it serves as the reference prescaler. When the monitor reports the crystal lost, the flag drops and the divider goes back to start-up timing. While the flag is low, or the generator is off, both references are held low. Reset is synchronous and active low. It is sampled in both clock domains, so it must be held for several edges of each clock. The enable, the slow select and the lost request are each resynchronised into every domain that uses them.

Top module: `cmref_divider`

## Requirements
- R1: While and just after reset, `ext_ref`, `int_ref`, `stab_clk` and `xtal_stable` are all 0.
- R2: While `gen_en` is low (after its 2-flop resynchronisation), `xtal_stable`, `stab_clk`, `ext_ref` and `int_ref` are 0, and the long counter is held at zero.
- R3: Number the rising `ext_clk` edges from 1, starting at the first edge that samples `gen_en` high. `xtal_stable` is 0 after edge 4097 and 1 after edge 4098.
- R4: While `xtal_stable` is 0, `stab_clk` is the long counter's top bit. With the numbering of R3 it rises after edge 2050. `xtal_stable` rises only on the edge where `stab_clk` falls.
- R5: With `slow_xtal` = 0, `ext_ref` is `ext_clk` divided by 512 with a 50% duty cycle (256 high).
- R6: With `slow_xtal` = 0, `int_ref` is `int_clk` divided by 4 with a 50% duty cycle.
- R7: With `slow_xtal` = 1, `ext_ref` is `ext_clk` divided by 4 with a 50% duty cycle.
- R8: With `slow_xtal` = 1, `int_ref` is `int_clk` divided by 64 with a 50% duty cycle (32 high).
- R9: While the stable flag is 0 in a domain (after resynchronisation), that domain's reference output is 0.
- R10: A `clk_lost` pulse of one `ext_clk` period, applied while `xtal_stable` is 1, clears the flag on the third rising edge after it is applied, and restarts the long counter at zero. `stab_clk` returns, and `xtal_stable` sets again 4096 edges after the clear.
- R11: If the resynchronised `clk_lost` is high on the edge where the start-up count completes, clearing wins: the flag stays 0. It sets at the next completed count once `clk_lost` is low.
- R12: `xtal_stable` falls only when `gen_en` goes low or `clk_lost` is asserted; ordinary clocking never clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_clk | input | 1 | External crystal clock |
| int_clk | input | 1 | Internal base clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| gen_en | input | 1 | External clock generator enable |
| slow_xtal | input | 1 | 0: long prescaler on the external reference; 1: on the internal reference |
| clk_lost | input | 1 | Monitor request, external clock judged inactive |
| ext_ref | output | 1 | Divided external reference |
| int_ref | output | 1 | Divided internal reference |
| stab_clk | output | 1 | Start-up timing clock, external clock divided by 4096 |
| xtal_stable | output | 1 | Crystal stable flag |

## Verification
Setting and clearing the stable flag can both fall on the same `ext_clk` edge: the start-up count completes just as a resynchronised lost request is present. The bench provokes this by raising `clk_lost` about 100 edges before the count would complete and holding it past that edge. It then checks that the flag is still low right after the expected set edge, still low one edge before the following count completes, and high exactly one count later. A second case covers the clear arriving while the flag is already set: a one-cycle pulse must drop the flag on a precisely numbered edge and restart a full-length start-up period.

// File: rtl/cmref_pkg.sv
// Shared definitions for the clock-monitor reference divider.
// Assumes: nothing beyond the standard language.
package cmref_pkg;

    // Which source receives the long prescaler.
    typedef enum logic {
        RATIO_FAST_XTAL = 1'b0,   // long prescaler on the external reference
        RATIO_SLOW_XTAL = 1'b1    // long prescaler on the internal reference
    } ratio_sel_e;

    // Resynchroniser depth used across the block.
    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/cmref_sync.sv
// Multi-flop resynchroniser for a single quasi-static or slowly changing bit.
// Assumes: STAGES >= 2; the input is held long enough to be seen by clk.
module cmref_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cmref_ext_div.sv
// External-clock domain: the shared long counter, the stable flag, the
// stabilization clock and the external reference.
// The counter first times crystal start-up (flag low). Once the flag is
// set it runs free and its bits supply the external reference.
// Assumes: the enable, slow select and lost request are asynchronous and
// are resynchronised here; the lost request clears the flag in preference
// to a completing count.
module cmref_ext_div
    import cmref_pkg::*;
#(
    parameter int LONG_LOG       = 12,
    parameter int PRE_LOG        = 2,
    parameter int FAST_EXTRA_LOG = 7,
    parameter int SYNC_STAGES    = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic slow_sel,
    input  logic lost,
    output logic ext_ref,
    output logic stab_clk,
    output logic stable
);

    localparam int MSB      = LONG_LOG - 1;
    localparam int SLOW_TAP = PRE_LOG - 1;
    localparam int FAST_TAP = PRE_LOG + FAST_EXTRA_LOG - 1;

    logic                en_s;
    logic                slow_raw;
    logic                lost_s;
    ratio_sel_e          slow_s;
    logic [LONG_LOG-1:0] long_cnt;
    logic                stable_q;
    logic                count_done;
    logic                clear_evt;

    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d(gen_en), .q(en_s)
    );
    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_sync (
        .clk(clk), .rst_n(rst_n), .d(slow_sel), .q(slow_raw)
    );
    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lost_sync (
        .clk(clk), .rst_n(rst_n), .d(lost), .q(lost_s)
    );

    assign slow_s     = ratio_sel_e'(slow_raw);
    assign count_done = en_s && (long_cnt == {LONG_LOG{1'b1}});
    assign clear_evt  = stable_q && lost_s;

    // Long counter: held while disabled, restarted when the flag is knocked down.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s) begin
            long_cnt <= '0;
        end else if (clear_evt) begin
            long_cnt <= '0;
        end else begin
            long_cnt <= long_cnt + 1'b1;
        end
    end

    // Stable flag: a lost request wins over a completing start-up count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s) begin
            stable_q <= 1'b0;
        end else if (lost_s) begin
            stable_q <= 1'b0;
        end else if (count_done) begin
            stable_q <= 1'b1;
        end
    end

    // Start-up clock runs only while the flag is low.
    assign stab_clk = en_s & ~stable_q & long_cnt[MSB];

    // Reference tap chosen by the slow-crystal select.
    assign ext_ref = en_s & stable_q &
                     ((slow_s == RATIO_SLOW_XTAL) ? long_cnt[SLOW_TAP] : long_cnt[FAST_TAP]);

    assign stable = stable_q;

    // R12: the flag drops only on a disable or a lost request.
    assert_flag_falls_only_on_request_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(stable_q) |-> $past(!en_s || lost_s)
    );

    // R4: the flag rises on the falling edge of the start-up clock.
    assert_flag_set_on_stab_fall_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(stable_q) |-> ($past(stab_clk) && !stab_clk)
    );

    // R2: a low enable leaves the flag clear and the counter at zero.
    assert_disable_clears_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !en_s |=> (!stable_q && long_cnt == '0)
    );

    // R11: with the flag low, a present lost request keeps it low.
    assert_lost_blocks_set_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (lost_s && !stable_q) |=> !stable_q
    );

endmodule

// File: rtl/cmref_int_div.sv
// Internal-clock domain: the divide-by-4 stage plus optional extra division
// for the internal reference.
// Assumes: the stable flag arrives from the external domain and is
// resynchronised here, together with the enable and slow select.
module cmref_int_div
    import cmref_pkg::*;
#(
    parameter int PRE_LOG        = 2,
    parameter int SLOW_EXTRA_LOG = 4,
    parameter int SYNC_STAGES    = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic slow_sel,
    input  logic stable_in,
    output logic int_ref
);

    localparam int CNT_W    = PRE_LOG + SLOW_EXTRA_LOG;
    localparam int FAST_TAP = PRE_LOG - 1;
    localparam int SLOW_TAP = CNT_W - 1;

    logic             en_s;
    logic             stab_s;
    logic             slow_raw;
    ratio_sel_e       slow_s;
    logic             run;
    logic [CNT_W-1:0] int_cnt;

    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d(gen_en), .q(en_s)
    );
    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stab_sync (
        .clk(clk), .rst_n(rst_n), .d(stable_in), .q(stab_s)
    );
    cmref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_sync (
        .clk(clk), .rst_n(rst_n), .d(slow_sel), .q(slow_raw)
    );

    assign slow_s = ratio_sel_e'(slow_raw);
    assign run    = en_s & stab_s;

    // Internal divider counts only while the crystal is enabled and stable.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            int_cnt <= '0;
        end else begin
            int_cnt <= int_cnt + 1'b1;
        end
    end

    // Reference tap chosen by the slow-crystal select.
    assign int_ref = run & ((slow_s == RATIO_SLOW_XTAL) ? int_cnt[SLOW_TAP] : int_cnt[FAST_TAP]);

    // R9: while not running, the divider sits at zero and the output is low.
    assert_int_held_when_unstable_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !run |=> (int_cnt == '0 && !int_ref)
    );

endmodule

// File: rtl/cmref_divider.sv
// Top level of the clock-monitor reference divider: ties the external
// domain (shared long counter, stable flag) to the internal domain.
// Assumes: rst_n is held for several edges of both clocks.
module cmref_divider
    import cmref_pkg::*;
#(
    parameter int LONG_LOG       = 12,
    parameter int PRE_LOG        = 2,
    parameter int FAST_EXTRA_LOG = 7,
    parameter int SLOW_EXTRA_LOG = 4,
    parameter int SYNC_STAGES    = DEF_SYNC_STAGES
) (
    input  logic ext_clk,
    input  logic int_clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic slow_xtal,
    input  logic clk_lost,
    output logic ext_ref,
    output logic int_ref,
    output logic stab_clk,
    output logic xtal_stable
);

    logic stable_ext;

    cmref_ext_div #(
        .LONG_LOG(LONG_LOG), .PRE_LOG(PRE_LOG),
        .FAST_EXTRA_LOG(FAST_EXTRA_LOG), .SYNC_STAGES(SYNC_STAGES)
    ) u_ext (
        .clk(ext_clk), .rst_n(rst_n), .gen_en(gen_en), .slow_sel(slow_xtal),
        .lost(clk_lost), .ext_ref(ext_ref), .stab_clk(stab_clk), .stable(stable_ext)
    );

    cmref_int_div #(
        .PRE_LOG(PRE_LOG), .SLOW_EXTRA_LOG(SLOW_EXTRA_LOG), .SYNC_STAGES(SYNC_STAGES)
    ) u_int (
        .clk(int_clk), .rst_n(rst_n), .gen_en(gen_en), .slow_sel(slow_xtal),
        .stable_in(stable_ext), .int_ref(int_ref)
    );

    assign xtal_stable = stable_ext;

endmodule

// File: tb/cmref_divider_bench.sv
// Directed bench for cmref_divider: one task per scenario.
module cmref_divider_bench;

    logic ext_clk = 1'b0;
    logic int_clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 1'b0;
    logic slow_xtal = 1'b0;
    logic clk_lost = 1'b0;
    logic ext_ref, int_ref, stab_clk, xtal_stable;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #10 ext_clk = ~ext_clk;   // 50 MHz
    always #13 int_clk = ~int_clk;

    cmref_divider u_cmref_divider (
        .ext_clk(ext_clk), .int_clk(int_clk), .rst_n(rst_n), .gen_en(gen_en),
        .slow_xtal(slow_xtal), .clk_lost(clk_lost), .ext_ref(ext_ref),
        .int_ref(int_ref), .stab_clk(stab_clk), .xtal_stable(xtal_stable)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Measure one output period and its high time in source-clock samples.
    task automatic measure(input bit use_int, output int period, output int high);
        bit started = 1'b0;
        logic prev;
        logic cur;
        period = 0;
        high = 0;
        prev = use_int ? int_ref : ext_ref;
        for (int i = 0; i < 6000; i++) begin
            if (use_int) begin
                @(negedge int_clk);
                cur = int_ref;
            end else begin
                @(negedge ext_clk);
                cur = ext_ref;
            end
            if (!prev && cur) begin
                if (started) break;
                started = 1'b1;
            end
            if (started) begin
                period++;
                if (cur) high++;
            end
            prev = cur;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (10) @(negedge ext_clk);
        check(xtal_stable == 1'b0, "R1", "stable in reset", xtal_stable, 0);
        check(stab_clk == 1'b0, "R1", "stab_clk in reset", stab_clk, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge ext_clk);
        check(ext_ref == 1'b0, "R1", "ext_ref after reset", ext_ref, 0);
        check(int_ref == 1'b0, "R1", "int_ref after reset", int_ref, 0);
    endtask

    // Enable the generator and time the start-up sequence edge by edge.
    task automatic t_startup;
        gen_en = 1'b1;
        for (int n = 1; n <= 4098; n++) begin
            @(negedge ext_clk);
            if (n == 2049) check(stab_clk == 1'b0, "R4", "stab_clk before rise", stab_clk, 0);
            if (n == 2050) check(stab_clk == 1'b1, "R4", "stab_clk after rise", stab_clk, 1);
            if (n == 4000) begin
                check(ext_ref == 1'b0, "R9", "ext_ref during start-up", ext_ref, 0);
                check(int_ref == 1'b0, "R9", "int_ref during start-up", int_ref, 0);
            end
            if (n == 4097) check(xtal_stable == 1'b0, "R3", "stable one edge early", xtal_stable, 0);
            if (n == 4098) begin
                check(xtal_stable == 1'b1, "R3", "stable on time", xtal_stable, 1);
                check(stab_clk == 1'b0, "R4", "stab_clk low once stable", stab_clk, 0);
            end
        end
    endtask

    task automatic t_ratio(input bit slow, input string rext, input string rint,
                           input int ext_per, input int int_per);
        int p;
        int h;
        int drops = 0;
        slow_xtal = slow;
        repeat (40) @(negedge ext_clk);
        measure(1'b0, p, h);   // settle the first period after the switch
        measure(1'b0, p, h);
        check(p == ext_per, rext, "ext_ref period", p, ext_per);
        check(h == ext_per / 2, rext, "ext_ref high time", h, ext_per / 2);
        measure(1'b1, p, h);
        measure(1'b1, p, h);
        check(p == int_per, rint, "int_ref period", p, int_per);
        check(h == int_per / 2, rint, "int_ref high time", h, int_per / 2);
        for (int i = 0; i < 600; i++) begin
            @(negedge ext_clk);
            if (!xtal_stable) drops++;
        end
        check(drops == 0, "R12", "flag lost without request", drops, 0);
    endtask

    // One-cycle lost pulse while stable: exact clear edge and full restart.
    task automatic t_lost;
        @(negedge ext_clk);
        clk_lost = 1'b1;
        for (int n = 1; n <= 4099; n++) begin
            @(negedge ext_clk);
            if (n == 1) clk_lost = 1'b0;
            if (n == 2) check(xtal_stable == 1'b1, "R10", "flag before clear", xtal_stable, 1);
            if (n == 3) begin
                check(xtal_stable == 1'b0, "R10", "flag cleared", xtal_stable, 0);
                check(ext_ref == 1'b0, "R9", "ext_ref after clear", ext_ref, 0);
            end
            if (n == 2050) check(stab_clk == 1'b0, "R10", "stab_clk before rise", stab_clk, 0);
            if (n == 2051) check(stab_clk == 1'b1, "R10", "stab_clk restarted", stab_clk, 1);
            if (n == 4098) check(xtal_stable == 1'b0, "R10", "flag one edge early", xtal_stable, 0);
            if (n == 4099) check(xtal_stable == 1'b1, "R10", "flag set again", xtal_stable, 1);
        end
    endtask

    task automatic t_disable;
        gen_en = 1'b0;
        repeat (6) @(negedge ext_clk);
        check(xtal_stable == 1'b0, "R2", "flag with enable low", xtal_stable, 0);
        check(stab_clk == 1'b0, "R2", "stab_clk with enable low", stab_clk, 0);
        check(ext_ref == 1'b0, "R2", "ext_ref with enable low", ext_ref, 0);
        repeat (6) @(negedge int_clk);
        check(int_ref == 1'b0, "R2", "int_ref with enable low", int_ref, 0);
    endtask

    // Lost request held across the edge where start-up would complete.
    task automatic t_collision;
        @(negedge ext_clk);
        gen_en = 1'b1;
        for (int n = 1; n <= 8194; n++) begin
            @(negedge ext_clk);
            if (n == 4000) clk_lost = 1'b1;
            if (n == 4200) clk_lost = 1'b0;
            if (n == 4098) check(xtal_stable == 1'b0, "R11", "set blocked by lost", xtal_stable, 0);
            if (n == 8193) check(xtal_stable == 1'b0, "R11", "flag one edge early", xtal_stable, 0);
            if (n == 8194) check(xtal_stable == 1'b1, "R11", "set on next count", xtal_stable, 1);
        end
    endtask

    initial begin
        t_reset();
        t_startup();
        t_ratio(1'b0, "R5", "R6", 512, 4);
        t_ratio(1'b1, "R7", "R8", 4, 64);
        t_lost();
        t_disable();
        t_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ext_clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule